// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller behind a 10-bit successive-approximation converter. Software sets a GO strobe. The sequencer then walks a trial code from the most significant bit downwards, one comparator decision per conversion-clock period (TAD). It loads the final code into a pair of right-justified result registers, raises a sticky interrupt flag and drops GO. The comparator and DAC sit outside the block. The block presents each trial code and samples a single decision bit in return.

TAD is derived either from the system clock, divided by 16, 32 or 64, or from a dedicated internal conversion clock. That clock reaches the block as a synchronous pulse, one per half TAD.

Software may clear GO at any point during a conversion. A clear that arrives before the last bit is resolved discards the conversion. A clear in the final half TAD, when every bit is already known, still loads the code but leaves the interrupt flag alone. Software running from a fast clock uses this late clear to end a conversion on its own timing.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, go_o and irq_o are 0 and res_hi_o, res_lo_o and trial_o are all zero.
- R2: With clk_sel_i = 0, 1 or 2, TAD lasts 16, 32 or 64 clock cycles, and a conversion lasts 11 TAD. go_o falls 176, 352 or 704 cycles after the edge that samples go_set_i.
- R3: With clk_sel_i = 3, each cycle with rc_tick_i high ends one half TAD. go_o stays high through the 21st such pulse and falls at the edge that samples the 22nd pulse.
- R4: The first trial code is 10'h200. Bit 9-k is decided at 1.5+k TAD after start from cmp_i (1 keeps the bit). The next lower bit is then set as the new trial. With an ideal comparator (cmp_i = trial_o <= input), the final code equals the input.
- R5: On normal completion, at a single edge, the code is loaded, irq_o is set and go_o is cleared.
- R6: Results are right-justified: res_hi_o[1:0] holds code bits 9:8, res_hi_o[7:2] reads 0, and res_lo_o holds code bits 7:0.
- R7: A go_clr_i sampled during a conversion at or before 21 half-TAD periods after start aborts it. go_o clears, and the result registers and irq_o keep their previous values.
- R8: A go_clr_i sampled later than 21 half-TAD periods after start, up to and including the completion edge, loads the full code and clears go_o without setting irq_o. On the completion edge, the clear takes priority.
- R9: A clear issued 4×43, 4×86 or 4×172 cycles after start (for clk_sel_i = 0, 1, 2) falls inside the R8 window and yields a loaded result.
- R10: go_set_i while a conversion runs has no effect on its timing or result. go_clr_i while idle changes no output.
- R11: clk_sel_i is captured at start. Changing it during a conversion does not alter that conversion's length.
- R12: irq_o stays set until irq_clr_i. If a completion and irq_clr_i share an edge, irq_o ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 2 | TAD source: 0 /16, 1 /32, 2 /64, 3 internal clock |
| rc_tick_i | input | 1 | Internal conversion clock, one pulse per half TAD |
| go_set_i | input | 1 | Start strobe (GO written to 1) |
| go_clr_i | input | 1 | Stop strobe (GO written to 0) |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| cmp_i | input | 1 | Comparator decision for the current trial code |
| trial_o | output | 10 | Trial code driven to the DAC |
| go_o | output | 1 | GO/DONE status, high while converting |
| irq_o | output | 1 | Sticky conversion-complete flag |
| res_hi_o | output | 8 | Result high register |
| res_lo_o | output | 8 | Result low register |

## Verification
The comparator is modelled ideally against a bench-held input code. Codes 0x000 and 0x3FF reveal a decision applied to the wrong bit or a missing final decision. Alternating patterns reveal bit-order swaps, and random codes cover the rest. Stop strobes are placed one cycle either side of the 21-half-TAD boundary and on the completion edge. These placements separate abort from late load, and late load from normal completion, while the instruction-cycle offsets confirm the window for each divisor. Redundant starts, idle stops, a mid-conversion divisor change and irregular internal-clock pulse spacing show that only the captured clock source governs conversion length.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    CKSEL_DIV16 = 2'd0,
    CKSEL_DIV32 = 2'd1,
    CKSEL_DIV64 = 2'd2,
    CKSEL_RC    = 2'd3
  } cksel_e;
endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen
  import sar_seq_pkg::*;
#(
  parameter int DIV_LOG_MIN = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  logic   restart_i,
  input  cksel_e sel_i,
  input  logic   rc_tick_i,
  output logic   half_tick_o
);
  localparam int CNT_W = DIV_LOG_MIN + 1;

  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] lim;
  logic             wrap;

  // half TAD = half the divisor
  always_comb begin
    case (sel_i)
      CKSEL_DIV16: lim = CNT_W'((1 << (DIV_LOG_MIN - 1)) - 1);
      CKSEL_DIV32: lim = CNT_W'((1 << DIV_LOG_MIN) - 1);
      CKSEL_DIV64: lim = CNT_W'((1 << (DIV_LOG_MIN + 1)) - 1);
      default:     lim = '0;
    endcase
  end

  assign wrap = (div_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (restart_i || !run_i) begin
      div_q <= '0;
    end else if (sel_i != CKSEL_RC) begin
      div_q <= wrap ? '0 : div_q + 1'b1;
    end
  end

  assign half_tick_o = run_i && ((sel_i == CKSEL_RC) ? rc_tick_i : wrap);

  AST_DIV_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sel_i != CKSEL_RC) |-> (div_q <= lim)); // R2

endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
  parameter int NB    = 10,
  parameter int IDX_W = $clog2(NB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             decide_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             cmp_i,
  output logic [NB-1:0]    code_o
);
  logic [NB-1:0] code_q;
  logic [NB-1:0] code_d;

  for (genvar gi = 0; gi < NB; gi++) begin : g_bit
    logic hit;
    assign hit = decide_i && (idx_i == IDX_W'(gi));
    if (gi == NB - 1) begin : g_msb
      assign code_d[gi] = start_i ? 1'b1 : (hit ? cmp_i : code_q[gi]);
    end else begin : g_low
      logic arm;
      // next trial bit is raised when the bit above is decided
      assign arm = decide_i && (idx_i == IDX_W'(gi + 1));
      assign code_d[gi] = start_i ? 1'b0 :
                          hit     ? cmp_i :
                          arm     ? 1'b1 : code_q[gi];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;

  AST_START_MSB_TRIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (code_q == NB'(1) << (NB - 1))); // R4

  AST_UPPER_BITS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && !start_i) |=>
      ((code_q >> ($past(idx_i) + 1)) == ($past(code_q) >> ($past(idx_i) + 1)))); // R4

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int NB    = 10,
  parameter int IDX_W = $clog2(NB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_set_i,
  input  logic             go_clr_i,
  input  logic             irq_clr_i,
  input  cksel_e           sel_i,
  input  logic             half_tick_i,
  input  logic [NB-1:0]    code_i,
  output logic             busy_o,
  output logic             start_o,
  output logic             decide_o,
  output logic [IDX_W-1:0] idx_o,
  output cksel_e           sel_q_o,
  output logic [NB-1:0]    res_o,
  output logic             irq_o
);
  localparam int LAST = 2 * NB + 1;
  localparam int HC_W = $clog2(LAST + 1);

  logic            busy_q;
  logic [HC_W-1:0] hcnt_q;
  cksel_e          sel_q;
  logic [NB-1:0]   res_q;
  logic            irq_q;
  logic            in_last;
  logic            finish;
  logic            stop;

  assign start_o = go_set_i && !busy_q;
  assign in_last = busy_q && (hcnt_q == HC_W'(LAST));
  assign stop    = busy_q && go_clr_i;
  assign finish  = in_last && half_tick_i && !go_clr_i;

  // decisions land at the end of even half periods 2..2*NB
  assign decide_o = busy_q && half_tick_i && !go_clr_i && !hcnt_q[0]
                    && (hcnt_q >= HC_W'(2)) && (hcnt_q <= HC_W'(2 * NB));

  always_comb begin
    int bit_pos;
    bit_pos = NB - int'(hcnt_q >> 1);
    idx_o   = IDX_W'(bit_pos);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hcnt_q <= '0;
      sel_q  <= CKSEL_DIV16;
    end else if (start_o) begin
      busy_q <= 1'b1;
      hcnt_q <= '0;
      sel_q  <= sel_i;
    end else if (stop || finish) begin
      busy_q <= 1'b0;
      hcnt_q <= '0;
    end else if (busy_q && half_tick_i) begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
    end else if (finish || (stop && in_last)) begin
      res_q <= code_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (finish)    irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign busy_o  = busy_q;
  assign sel_q_o = sel_q;
  assign res_o   = res_q;
  assign irq_o   = irq_q;

  AST_FINISH_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish |=> (!busy_q && irq_q)); // R5

  AST_SET_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && go_set_i && !go_clr_i && !half_tick_i) |=> (busy_q && $stable(hcnt_q))); // R10

  AST_ABORT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !in_last) |=> ($stable(res_q) && !$rose(irq_q) && !busy_q)); // R7

  AST_LATE_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && in_last) |=> (!$rose(irq_q) && !busy_q)); // R8

  AST_HALF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (hcnt_q <= HC_W'(LAST))); // R2

  AST_SEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (!busy_q || $stable(sel_q))); // R11

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int NB          = 10,
  parameter int REG_W       = 8,
  parameter int DIV_LOG_MIN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       clk_sel_i,
  input  logic             rc_tick_i,
  input  logic             go_set_i,
  input  logic             go_clr_i,
  input  logic             irq_clr_i,
  input  logic             cmp_i,
  output logic [NB-1:0]    trial_o,
  output logic             go_o,
  output logic             irq_o,
  output logic [REG_W-1:0] res_hi_o,
  output logic [REG_W-1:0] res_lo_o
);
  localparam int IDX_W = $clog2(NB);

  logic             busy;
  logic             start;
  logic             decide;
  logic [IDX_W-1:0] idx;
  cksel_e           sel_q;
  logic             half_tick;
  logic [NB-1:0]    code;
  logic [NB-1:0]    res;
  logic [2*REG_W-1:0] res_ext;

  sar_seq_ctrl #(.NB(NB), .IDX_W(IDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_set_i    (go_set_i),
    .go_clr_i    (go_clr_i),
    .irq_clr_i   (irq_clr_i),
    .sel_i       (cksel_e'(clk_sel_i)),
    .half_tick_i (half_tick),
    .code_i      (code),
    .busy_o      (busy),
    .start_o     (start),
    .decide_o    (decide),
    .idx_o       (idx),
    .sel_q_o     (sel_q),
    .res_o       (res),
    .irq_o       (irq_o)
  );

  sar_tad_gen #(.DIV_LOG_MIN(DIV_LOG_MIN)) u_tad (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (busy),
    .restart_i   (start),
    .sel_i       (sel_q),
    .rc_tick_i   (rc_tick_i),
    .half_tick_o (half_tick)
  );

  sar_bit_reg #(.NB(NB), .IDX_W(IDX_W)) u_bits (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .decide_i (decide),
    .idx_i    (idx),
    .cmp_i    (cmp_i),
    .code_o   (code)
  );

  // right-justified across two registers
  assign res_ext  = (2 * REG_W)'(res);
  assign res_hi_o = res_ext[2*REG_W-1:REG_W];
  assign res_lo_o = res_ext[REG_W-1:0];
  assign trial_o  = code;
  assign go_o     = busy;

endmodule

// File: tb/sar_conv_seq_test.sv
`timescale 1ns/1ps
module sar_conv_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic       rc_tick = 1'b0;
  logic       go_set = 1'b0;
  logic       go_clr = 1'b0;
  logic       irq_clr = 1'b0;
  logic [9:0] vin = '0;
  logic       cmp;
  logic [9:0] trial;
  logic       go;
  logic       irq;
  logic [7:0] res_hi;
  logic [7:0] res_lo;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign cmp = (trial <= vin);  // ideal comparator

  sar_conv_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(clk_sel), .rc_tick_i(rc_tick),
    .go_set_i(go_set), .go_clr_i(go_clr), .irq_clr_i(irq_clr), .cmp_i(cmp),
    .trial_o(trial), .go_o(go), .irq_o(irq), .res_hi_o(res_hi), .res_lo_o(res_lo)
  );

  function automatic int half_of(input int sel);
    return 8 << sel;
  endfunction

  function automatic int code_of(input logic [7:0] hi, input logic [7:0] lo);
    return int'({hi[1:0], lo});
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic drop_irq();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  // Start a divided-clock conversion; events are cycle offsets after the start edge (0 = none).
  task automatic convert(input string tag, input int sel, input logic [9:0] v,
                         input int clr_at, input int set_at, input int chg_at,
                         input int irqclr_at, input bit pre_drop);
    int h, full, dur, prev, exp_res, exp_irq, exp_dur;
    if (pre_drop) drop_irq();
    h = half_of(sel);
    full = 22 * h;
    prev = code_of(res_hi, res_lo);
    clk_sel = 2'(sel);
    vin = v;
    go_set = 1'b1;
    @(negedge clk);
    go_set = 1'b0;
    dur = 0;
    while (go && dur < 2000) begin
      go_clr  = (clr_at != 0) && (dur + 1 == clr_at);
      go_set  = (set_at != 0) && (dur + 1 == set_at);
      irq_clr = (irqclr_at != 0) && (dur + 1 == irqclr_at);
      if (chg_at != 0 && dur + 1 == chg_at) clk_sel = 2'(2 - sel);
      @(negedge clk);
      dur++;
    end
    go_clr = 1'b0; go_set = 1'b0; irq_clr = 1'b0;
    if (clr_at == 0 || clr_at > full) begin
      exp_dur = full; exp_res = int'(v); exp_irq = 1;
    end else if (clr_at > 21 * h) begin
      exp_dur = clr_at; exp_res = int'(v); exp_irq = 0;
    end else begin
      exp_dur = clr_at; exp_res = prev; exp_irq = 0;
    end
    if (!pre_drop && exp_irq == 0) exp_irq = -1;
    chk({tag, " length"}, dur, exp_dur);
    chk({tag, " result"}, code_of(res_hi, res_lo), exp_res);
    chk({tag, " R6 high pad"}, int'(res_hi[7:2]), 0);
    if (exp_irq >= 0) chk({tag, " irq"}, int'(irq), exp_irq);
  endtask

  task automatic convert_rc(input string tag, input logic [9:0] v, input int gap_seed);
    drop_irq();
    clk_sel = 2'd3;
    vin = v;
    go_set = 1'b1;
    @(negedge clk);
    go_set = 1'b0;
    for (int i = 1; i <= 22; i++) begin
      repeat (1 + ((gap_seed + i * 7) % 5)) @(negedge clk);
      rc_tick = 1'b1;
      @(negedge clk);
      rc_tick = 1'b0;
      if (i == 21) chk({tag, " R3 busy before last pulse"}, int'(go), 1);
    end
    chk({tag, " R3 done after 22 pulses"}, int'(go), 0);
    chk({tag, " R3 result"}, code_of(res_hi, res_lo), int'(v));
    chk({tag, " R5 irq"}, int'(irq), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int prev;
    void'($urandom(32'd7781));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 go", int'(go), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 res_hi", int'(res_hi), 0);
    chk("R1 res_lo", int'(res_lo), 0);
    chk("R1 trial", int'(trial), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 first trial code
    clk_sel = 2'd0; vin = 10'h155; go_set = 1'b1;
    @(negedge clk);
    go_set = 1'b0;
    chk("R4 first trial", int'(trial), 'h200);
    go_clr = 1'b1;
    @(negedge clk);
    go_clr = 1'b0;

    // R2 R4 R5 directed codes on each divisor
    convert("R2 R4 div16 zero",   0, 10'h000, 0, 0, 0, 0, 1);
    convert("R2 R4 div32 full",   1, 10'h3FF, 0, 0, 0, 0, 1);
    convert("R2 R4 div64 alt",    2, 10'h2AA, 0, 0, 0, 0, 1);
    convert("R5 R6 div16 alt",    0, 10'h155, 0, 0, 0, 0, 1);

    // R12 sticky flag and clear
    chk("R12 sticky", int'(irq), 1);
    drop_irq();
    chk("R12 cleared", int'(irq), 0);
    // R12 completion wins over clear on the same edge
    convert("R12 set wins", 1, 10'h0F0, 0, 0, 0, 22 * 16, 1);

    // R7 abort at the last abort cycle, R8 late clears
    convert("R7 abort edge",     1, 10'h3C3, 21 * 16, 0, 0, 0, 1);
    convert("R7 abort early",    0, 10'h011, 30, 0, 0, 0, 1);
    convert("R8 first late",     1, 10'h1E7, 21 * 16 + 1, 0, 0, 0, 1);
    convert("R8 completion edge",0, 10'h2D4, 22 * 8, 0, 0, 0, 1);

    // R9 instruction-cycle clear points
    convert("R9 div16",  0, 10'h099, 4 * 43,  0, 0, 0, 1);
    convert("R9 div32",  1, 10'h366, 4 * 86,  0, 0, 0, 1);
    convert("R9 div64",  2, 10'h21B, 4 * 172, 0, 0, 0, 1);

    // R10 redundant start, idle stop
    convert("R10 set while busy", 1, 10'h0AB, 0, 100, 0, 0, 1);
    prev = code_of(res_hi, res_lo);
    go_clr = 1'b1;
    @(negedge clk);
    go_clr = 1'b0;
    @(negedge clk);
    chk("R10 idle clear go", int'(go), 0);
    chk("R10 idle clear result", code_of(res_hi, res_lo), prev);
    chk("R10 idle clear irq", int'(irq), 1);

    // R11 divisor change mid-conversion
    convert("R11 sel change", 0, 10'h301, 0, 0, 5, 0, 1);

    // R3 internal clock
    convert_rc("R3 rc a", 10'h1C8, 3);
    convert_rc("R3 rc b", 10'h3FE, 11);

    // random mix
    for (int n = 0; n < 24; n++) begin
      int sel, clr_at, set_at, full;
      sel = int'($urandom % 3);
      full = 22 * half_of(sel);
      clr_at = ($urandom % 2 == 0) ? 0 : 1 + int'($urandom % (full + 4));
      set_at = ($urandom % 3 == 0) ? 1 + int'($urandom % (full - 1)) : 0;
      convert("R4 R7 R8 random", sel, 10'($urandom), clr_at, set_at, 0, 0, 1);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule